// File: doc/BRIEF.md
# Clock Group Stop Controller

This block sits between a clock synthesizer and the output pads. It takes three families of already-generated clocks: a processor group, a peripheral-bus group and a memory group. It decides, output by output, whether each clock is passed on or held low. There are two sources of control. The first is an active-low stop pin per group; these pins arrive asynchronously and only take effect while the mobile mode pin is high. The second is a static enable bit per output. One peripheral-bus output always runs and ignores its group's stop pin. The last processor output can be set to run freely or to follow its group.

Each group synchronizes its own stop pin into its own clock domain. A gate register per output is updated on the falling edge of the group clock, so the gate can only change while the clock is low. As a result, a stopped output stays low, the last pulse before a stop completes its full high phase, and the first pulse after a restart is a full high phase. After each restart, a group keeps running for a minimum number of its own clocks: 100 for the processor group and 10 for the bus group.

Top module: `clkgrp_stop_ctrl`

## Requirements
- R1: While `rst_n` is low every output is held low.
- R2: A gated output changes only while its group clock is low, so each high pulse lasts exactly half a group clock period and a stopped output rests at 0.
- R3: The stop pins take effect only when `mobile_mode` is 1; with `mobile_mode` at 0 every enabled output toggles regardless of the stop pins.
- R4: After `cpu_stop_n` falls, the processor outputs show at most 4 further rising edges. After it rises, the first rising edge appears within 4 processor clocks.
- R5: Once the processor group restarts, it delivers at least 100 pulses before it stops again, even if the stop request returns sooner.
- R6: With `pci_stop_n` low in mobile mode, `pci_out[5:1]` stop within 3 bus clocks. After a restart they run for at least 10 bus clocks.
- R7: `pci_out[0]` keeps toggling whatever the state of `pci_stop_n`.
- R8: An enable bit of 0 (`cpu_en`, `pci_en`, `sdr_en`, bit i for output i) holds that output low with no edges.
- R9: With `cpu_last_free` = 1, `cpu_out[2]` keeps running while the processor group is stopped. With 0, it stops with the group.
- R10: With `sdr_stop_n` low in mobile mode, all memory outputs stop low after completing the current high phase. After release they restart with full pulses.
- R11: A stop pulse that no synchronizer edge samples causes no change. A short pulse that is sampled may drop pulses but never produces a shortened one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor group source clock |
| pci_clk | input | 1 | Peripheral-bus group source clock |
| sdr_clk | input | 1 | Memory group source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mobile_mode | input | 1 | 1 = stop pins honoured, 0 = stop pins ignored |
| cpu_stop_n | input | 1 | Asynchronous active-low processor group stop |
| pci_stop_n | input | 1 | Asynchronous active-low bus group stop |
| sdr_stop_n | input | 1 | Asynchronous active-low memory group stop |
| cpu_en | input | 3 | Per-output enable, processor group |
| pci_en | input | 6 | Per-output enable, bus group (bit 0 free-running) |
| sdr_en | input | 13 | Per-output enable, memory group |
| cpu_last_free | input | 1 | 1 = last processor output ignores its stop pin |
| cpu_out | output | 3 | Gated processor clocks |
| pci_out | output | 6 | Gated bus clocks |
| sdr_out | output | 13 | Gated memory clocks |

## Verification
Every cycle, the assertions check three things: each gate register changes only while its clock is low, a disabled output's gate stays closed, and the free bus output's gate stays open when enabled. On every processor and bus stop, they also check that the group ran its minimum number of clocks since the last restart. The latency bounds, the effect of the mode pin and of the free-run selection, and the recovery from short stop pulses depend on edge counts over chosen windows. The bench's scenarios are the only place these are shown, and its pulse-width monitor confirms at the pins what the gate assertions check inside.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

    // Phase of one clock group.
    typedef enum logic {
        GRP_HALTED  = 1'b0,
        GRP_RUNNING = 1'b1
    } grp_phase_e;

    // Counter width able to hold the minimum-run limit plus one spare code.
    function automatic int cnt_width(input int limit);
        return $clog2(limit + 2);
    endfunction

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for one asynchronous level (STAGES >= 2).
module clkstop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    typedef struct packed {
        logic [STAGES-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.pipe[STAGES-1];

endmodule

// File: rtl/clkstop_group.sv
`timescale 1ns/1ps
// One clock group: synchronized stop request, minimum-run counter and
// falling-edge gate registers, one per output.
module clkstop_group
    import clkstop_pkg::*;
#(
    parameter int N           = 3,
    parameter int MIN_RUN     = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_async,
    input  logic [N-1:0] en,
    input  logic [N-1:0] free_run,
    output logic [N-1:0] clk_out,
    output logic [N-1:0] gate_o,
    output logic         run_o
);

    localparam int            CW      = cnt_width(MIN_RUN);
    localparam logic [CW-1:0] RUN_LIM = CW'(MIN_RUN);

    logic req_s;

    clkstop_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_async),
        .q     (req_s)
    );

    typedef struct packed {
        grp_phase_e    phase;
        logic [CW-1:0] runcnt;
        logic [N-1:0]  gate;
    } grp_st_t;

    grp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == GRP_RUNNING) begin
            // Count clocks since restart; stop only once the limit is met.
            if (st_q.runcnt != RUN_LIM) begin
                st_d.runcnt = st_q.runcnt + 1'b1;
            end else if (req_s) begin
                st_d.phase = GRP_HALTED;
            end
        end else begin
            if (!req_s) begin
                st_d.phase  = GRP_RUNNING;
                st_d.runcnt = '0;
            end
        end
        st_d.gate = en & (free_run | {N{st_d.phase == GRP_RUNNING}});
    end

    // Falling-edge registers: gates only move while the clock is low.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase  <= GRP_RUNNING;
            st_q.runcnt <= RUN_LIM;
            st_q.gate   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_out = {N{clk}} & st_q.gate;
    assign gate_o  = st_q.gate;
    assign run_o   = (st_q.phase == GRP_RUNNING);

endmodule

// File: rtl/clkgrp_stop_ctrl.sv
`timescale 1ns/1ps
module clkgrp_stop_ctrl
    import clkstop_pkg::*;
#(
    parameter int               N_CPU         = 3,
    parameter int               N_PCI         = 6,
    parameter int               N_SDR         = 13,
    parameter int               CPU_MIN_RUN   = 100,
    parameter int               PCI_MIN_RUN   = 10,
    parameter int               SDR_MIN_RUN   = 1,
    parameter int               SYNC_STAGES   = 2,
    parameter logic [N_PCI-1:0] PCI_FREE_MASK = N_PCI'(1)
) (
    input  logic             cpu_clk,
    input  logic             pci_clk,
    input  logic             sdr_clk,
    input  logic             rst_n,
    input  logic             mobile_mode,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic             sdr_stop_n,
    input  logic [N_CPU-1:0] cpu_en,
    input  logic [N_PCI-1:0] pci_en,
    input  logic [N_SDR-1:0] sdr_en,
    input  logic             cpu_last_free,
    output logic [N_CPU-1:0] cpu_out,
    output logic [N_PCI-1:0] pci_out,
    output logic [N_SDR-1:0] sdr_out
);

    localparam int CPU_FLEX = N_CPU - 1;

    logic [N_CPU-1:0] cpu_free;
    logic [N_CPU-1:0] cpu_gate;
    logic [N_PCI-1:0] pci_gate;
    logic [N_SDR-1:0] sdr_gate;
    logic             cpu_run;
    logic             pci_run;
    logic             sdr_run;
    logic             cpu_req;
    logic             pci_req;
    logic             sdr_req;

    always_comb begin
        cpu_free           = '0;
        cpu_free[CPU_FLEX] = cpu_last_free;
        cpu_req            = mobile_mode & ~cpu_stop_n;
        pci_req            = mobile_mode & ~pci_stop_n;
        sdr_req            = mobile_mode & ~sdr_stop_n;
    end

    clkstop_group #(
        .N (N_CPU), .MIN_RUN (CPU_MIN_RUN), .SYNC_STAGES (SYNC_STAGES)
    ) u_cpu (
        .clk (cpu_clk), .rst_n (rst_n), .req_async (cpu_req),
        .en (cpu_en), .free_run (cpu_free),
        .clk_out (cpu_out), .gate_o (cpu_gate), .run_o (cpu_run)
    );

    clkstop_group #(
        .N (N_PCI), .MIN_RUN (PCI_MIN_RUN), .SYNC_STAGES (SYNC_STAGES)
    ) u_pci (
        .clk (pci_clk), .rst_n (rst_n), .req_async (pci_req),
        .en (pci_en), .free_run (PCI_FREE_MASK),
        .clk_out (pci_out), .gate_o (pci_gate), .run_o (pci_run)
    );

    clkstop_group #(
        .N (N_SDR), .MIN_RUN (SDR_MIN_RUN), .SYNC_STAGES (SYNC_STAGES)
    ) u_sdr (
        .clk (sdr_clk), .rst_n (rst_n), .req_async (sdr_req),
        .en (sdr_en), .free_run ('0),
        .clk_out (sdr_out), .gate_o (sdr_gate), .run_o (sdr_run)
    );

endmodule

// File: rtl/clkgrp_stop_chk.sv
`timescale 1ns/1ps
module clkgrp_stop_chk #(
    parameter int               N_CPU         = 3,
    parameter int               N_PCI         = 6,
    parameter int               N_SDR         = 13,
    parameter int               CPU_MIN_RUN   = 100,
    parameter int               PCI_MIN_RUN   = 10,
    parameter int               SDR_MIN_RUN   = 1,
    parameter logic [N_PCI-1:0] PCI_FREE_MASK = N_PCI'(1)
) (
    input logic             cpu_clk,
    input logic             pci_clk,
    input logic             sdr_clk,
    input logic             rst_n,
    input logic [N_CPU-1:0] cpu_en,
    input logic [N_PCI-1:0] pci_en,
    input logic [N_SDR-1:0] sdr_en,
    input logic [N_CPU-1:0] cpu_gate,
    input logic [N_PCI-1:0] pci_gate,
    input logic [N_SDR-1:0] sdr_gate,
    input logic             cpu_run,
    input logic             pci_run,
    input logic             sdr_run
);

    localparam int CLW = $clog2(CPU_MIN_RUN + 2);
    localparam int PLW = $clog2(PCI_MIN_RUN + 2);
    localparam int SLW = $clog2(SDR_MIN_RUN + 2);

    logic [1:0]     up_cpu, up_pci, up_sdr;
    logic [CLW-1:0] cpu_len;
    logic [PLW-1:0] pci_len;
    logic [SLW-1:0] sdr_len;

    always_ff @(posedge cpu_clk or negedge rst_n) begin
        if (!rst_n) up_cpu <= '0;
        else if (up_cpu != 2'd3) up_cpu <= up_cpu + 2'd1;
    end
    always_ff @(posedge pci_clk or negedge rst_n) begin
        if (!rst_n) up_pci <= '0;
        else if (up_pci != 2'd3) up_pci <= up_pci + 2'd1;
    end
    always_ff @(posedge sdr_clk or negedge rst_n) begin
        if (!rst_n) up_sdr <= '0;
        else if (up_sdr != 2'd3) up_sdr <= up_sdr + 2'd1;
    end

    // Clocks run since the last restart, saturating at the limit.
    always_ff @(negedge cpu_clk or negedge rst_n) begin
        if (!rst_n) cpu_len <= CLW'(CPU_MIN_RUN);
        else if (!cpu_run) cpu_len <= '0;
        else if (cpu_len != CLW'(CPU_MIN_RUN)) cpu_len <= cpu_len + 1'b1;
    end
    always_ff @(negedge pci_clk or negedge rst_n) begin
        if (!rst_n) pci_len <= PLW'(PCI_MIN_RUN);
        else if (!pci_run) pci_len <= '0;
        else if (pci_len != PLW'(PCI_MIN_RUN)) pci_len <= pci_len + 1'b1;
    end
    always_ff @(negedge sdr_clk or negedge rst_n) begin
        if (!rst_n) sdr_len <= SLW'(SDR_MIN_RUN);
        else if (!sdr_run) sdr_len <= '0;
        else if (sdr_len != SLW'(SDR_MIN_RUN)) sdr_len <= sdr_len + 1'b1;
    end

    // R2: a gate may move only while its group clock is low.
    always @(cpu_gate) begin
        if (rst_n === 1'b1) begin
            p_gate_lowphase_cpu_r2: assert (cpu_clk == 1'b0)
                else $error("cpu gate moved while clock high");
        end
    end
    always @(pci_gate) begin
        if (rst_n === 1'b1) begin
            p_gate_lowphase_pci_r2: assert (pci_clk == 1'b0)
                else $error("pci gate moved while clock high");
        end
    end
    always @(sdr_gate) begin
        if (rst_n === 1'b1) begin
            p_gate_lowphase_sdr_r2: assert (sdr_clk == 1'b0)
                else $error("sdr gate moved while clock high");
        end
    end

    // R8: an output disabled across a whole cycle keeps its gate closed.
    p_en_off_cpu_r8: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        (up_cpu == 2'd3) |-> ((~cpu_en & ~$past(cpu_en) & cpu_gate) == '0));
    p_en_off_pci_r8: assert property (@(posedge pci_clk) disable iff (!rst_n)
        (up_pci == 2'd3) |-> ((~pci_en & ~$past(pci_en) & pci_gate) == '0));
    p_en_off_sdr_r8: assert property (@(posedge sdr_clk) disable iff (!rst_n)
        (up_sdr == 2'd3) |-> ((~sdr_en & ~$past(sdr_en) & sdr_gate) == '0));

    // R7: the free bus output stays open while enabled.
    p_free_pci_r7: assert property (@(posedge pci_clk) disable iff (!rst_n)
        (up_pci == 2'd3) |->
        ((pci_en & $past(pci_en) & PCI_FREE_MASK & ~pci_gate) == '0));

    // R5 / R6: no stop before the minimum run has elapsed.
    p_minrun_cpu_r5: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        $fell(cpu_run) |-> (cpu_len >= CLW'(CPU_MIN_RUN)));
    p_minrun_pci_r6: assert property (@(negedge pci_clk) disable iff (!rst_n)
        $fell(pci_run) |-> (pci_len >= PLW'(PCI_MIN_RUN)));
    p_minrun_sdr_r10: assert property (@(negedge sdr_clk) disable iff (!rst_n)
        $fell(sdr_run) |-> (sdr_len >= SLW'(SDR_MIN_RUN)));

endmodule

bind clkgrp_stop_ctrl clkgrp_stop_chk #(
    .N_CPU (N_CPU), .N_PCI (N_PCI), .N_SDR (N_SDR),
    .CPU_MIN_RUN (CPU_MIN_RUN), .PCI_MIN_RUN (PCI_MIN_RUN),
    .SDR_MIN_RUN (SDR_MIN_RUN), .PCI_FREE_MASK (PCI_FREE_MASK)
) u_chk (
    .cpu_clk (cpu_clk), .pci_clk (pci_clk), .sdr_clk (sdr_clk),
    .rst_n (rst_n),
    .cpu_en (cpu_en), .pci_en (pci_en), .sdr_en (sdr_en),
    .cpu_gate (cpu_gate), .pci_gate (pci_gate), .sdr_gate (sdr_gate),
    .cpu_run (cpu_run), .pci_run (pci_run), .sdr_run (sdr_run)
);

// File: tb/tb_clkgrp_stop_ctrl.sv
`timescale 1ns/1ps
module tb_clkgrp_stop_ctrl;

    localparam int  N_CPU    = 3;
    localparam int  N_PCI    = 6;
    localparam int  N_SDR    = 13;
    localparam time CPU_HALF = 4;
    localparam time PCI_HALF = 15;
    localparam time SDR_HALF = 5;

    logic cpu_clk = 1'b0, pci_clk = 1'b0, sdr_clk = 1'b0;
    logic rst_n = 1'b0, mobile_mode = 1'b0, cpu_last_free = 1'b0;
    logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, sdr_stop_n = 1'b1;
    logic [N_CPU-1:0] cpu_en = '1;
    logic [N_PCI-1:0] pci_en = '1;
    logic [N_SDR-1:0] sdr_en = '1;
    logic [N_CPU-1:0] cpu_out;
    logic [N_PCI-1:0] pci_out;
    logic [N_SDR-1:0] sdr_out;

    always #(CPU_HALF) cpu_clk = ~cpu_clk;
    always #(PCI_HALF) pci_clk = ~pci_clk;
    always #(SDR_HALF) sdr_clk = ~sdr_clk;

    clkgrp_stop_ctrl dut (
        .cpu_clk (cpu_clk), .pci_clk (pci_clk), .sdr_clk (sdr_clk),
        .rst_n (rst_n), .mobile_mode (mobile_mode),
        .cpu_stop_n (cpu_stop_n), .pci_stop_n (pci_stop_n), .sdr_stop_n (sdr_stop_n),
        .cpu_en (cpu_en), .pci_en (pci_en), .sdr_en (sdr_en),
        .cpu_last_free (cpu_last_free),
        .cpu_out (cpu_out), .pci_out (pci_out), .sdr_out (sdr_out)
    );

    int checks = 0;
    int fails  = 0;

    // ---------------- pin monitors: edge counts and pulse widths --------
    int  cpu_cnt [N_CPU] = '{default: 0};
    int  pci_cnt [N_PCI] = '{default: 0};
    int  sdr_cnt [N_SDR] = '{default: 0};
    time cpu_rise[N_CPU] = '{default: 0};
    time pci_rise[N_PCI] = '{default: 0};
    time sdr_rise[N_SDR] = '{default: 0};
    int  cpu_runt = 0, pci_runt = 0, sdr_runt = 0;
    logic [N_CPU-1:0] cpu_prev = '0;
    logic [N_PCI-1:0] pci_prev = '0;
    logic [N_SDR-1:0] sdr_prev = '0;

    always @(cpu_out) begin
        for (int i = 0; i < N_CPU; i++) begin
            if (cpu_out[i] === 1'b1 && cpu_prev[i] == 1'b0) begin
                cpu_cnt[i]++;
                cpu_rise[i] = $time;
                if (!cpu_clk) cpu_runt++;
            end else if (cpu_out[i] === 1'b0 && cpu_prev[i] == 1'b1) begin
                if (cpu_clk || ($time - cpu_rise[i]) != CPU_HALF) cpu_runt++;
            end
        end
        cpu_prev = cpu_out;
    end

    always @(pci_out) begin
        for (int i = 0; i < N_PCI; i++) begin
            if (pci_out[i] === 1'b1 && pci_prev[i] == 1'b0) begin
                pci_cnt[i]++;
                pci_rise[i] = $time;
                if (!pci_clk) pci_runt++;
            end else if (pci_out[i] === 1'b0 && pci_prev[i] == 1'b1) begin
                if (pci_clk || ($time - pci_rise[i]) != PCI_HALF) pci_runt++;
            end
        end
        pci_prev = pci_out;
    end

    always @(sdr_out) begin
        for (int i = 0; i < N_SDR; i++) begin
            if (sdr_out[i] === 1'b1 && sdr_prev[i] == 1'b0) begin
                sdr_cnt[i]++;
                sdr_rise[i] = $time;
                if (!sdr_clk) sdr_runt++;
            end else if (sdr_out[i] === 1'b0 && sdr_prev[i] == 1'b1) begin
                if (sdr_clk || ($time - sdr_rise[i]) != SDR_HALF) sdr_runt++;
            end
        end
        sdr_prev = sdr_out;
    end

    // ---------------- scoreboard ----------------------------------------
    typedef struct {
        string req;
        int    grp;
        int    idx;
        int    base;
        int    lo;
        int    hi;
    } exp_t;

    exp_t sb_q[$];
    event flush_ev, flushed_ev;

    function automatic int get_cnt(input int grp, input int idx);
        case (grp)
            0:       return cpu_cnt[idx];
            1:       return pci_cnt[idx];
            default: return sdr_cnt[idx];
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver side: expect lo..hi rising edges on an output until the flush.
    task automatic arm(input string req, input int grp, input int idx,
                       input int lo, input int hi);
        exp_t e;
        e = '{req, grp, idx, get_cnt(grp, idx), lo, hi};
        sb_q.push_back(e);
    endtask

    task automatic flush();
        -> flush_ev;
        @(flushed_ev);
    endtask

    // Monitor side: pop and compare.
    initial begin
        forever begin
            @(flush_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                int   d;
                e = sb_q.pop_front();
                d = get_cnt(e.grp, e.idx) - e.base;
                checks++;
                if (d < e.lo || d > e.hi) begin
                    fails++;
                    $display("FAIL %s group%0d out%0d edges actual=%0d expected=%0d..%0d",
                             e.req, e.grp, e.idx, d, e.lo, e.hi);
                end
            end
            -> flushed_ev;
        end
    end

    task automatic wait_cpu(input int n);
        repeat (n) @(posedge cpu_clk);
        #2;
    endtask
    task automatic wait_pci(input int n);
        repeat (n) @(posedge pci_clk);
        #2;
    endtask
    task automatic wait_sdr(input int n);
        repeat (n) @(posedge sdr_clk);
        #2;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(64'd1_600_000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    // ---------------- stimulus ------------------------------------------
    initial begin
        // R1: reset holds every output low
        arm("R1", 0, 0, 0, 0);
        wait_cpu(5);
        flush();
        check(cpu_out == '0, "R1", "cpu_out in reset", cpu_out, 0);
        check(pci_out == '0, "R1", "pci_out in reset", pci_out, 0);
        check(sdr_out == '0, "R1", "sdr_out in reset", sdr_out, 0);
        rst_n = 1'b1;
        wait_cpu(120);

        // R3: desktop mode ignores the stop pins
        cpu_stop_n = 1'b0; pci_stop_n = 1'b0; sdr_stop_n = 1'b0;
        wait_cpu(10);
        arm("R3", 0, 0, 39, 41);
        arm("R3", 1, 1, 9, 12);
        arm("R3", 2, 0, 31, 33);
        wait_cpu(40);
        flush();

        // R8: disabled outputs stay low
        cpu_en[1] = 1'b0; pci_en[3] = 1'b0; sdr_en[5] = 1'b0;
        wait_cpu(5);
        arm("R8", 0, 1, 0, 0);
        arm("R8", 1, 3, 0, 0);
        arm("R8", 2, 5, 0, 0);
        arm("R8", 0, 0, 39, 41);
        wait_cpu(40);
        flush();
        check(cpu_out[1] == 1'b0, "R8", "cpu_out[1] level", cpu_out[1], 0);
        check(pci_out[3] == 1'b0, "R8", "pci_out[3] level", pci_out[3], 0);
        check(sdr_out[5] == 1'b0, "R8", "sdr_out[5] level", sdr_out[5], 0);
        cpu_en = '1; pci_en = '1; sdr_en = '1;

        // R4 / R9: processor stop latency and the free last output
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1; sdr_stop_n = 1'b1;
        mobile_mode = 1'b1;
        cpu_last_free = 1'b1;
        wait_cpu(130);
        cpu_stop_n = 1'b0;
        arm("R4", 0, 0, 0, 4);
        wait_cpu(6);
        flush();
        arm("R4", 0, 0, 0, 0);
        arm("R4", 0, 1, 0, 0);
        arm("R9", 0, 2, 39, 41);
        arm("R3", 1, 1, 9, 12);
        arm("R3", 2, 0, 31, 33);
        wait_cpu(40);
        flush();
        check(cpu_out[1:0] == 2'b00, "R4", "stopped cpu level", cpu_out[1:0], 0);
        cpu_last_free = 1'b0;
        wait_cpu(5);
        arm("R9", 0, 2, 0, 0);
        wait_cpu(20);
        flush();

        // R4: restart latency; R5: minimum run after restart
        cpu_stop_n = 1'b1;
        arm("R4", 0, 0, 1, 4);
        wait_cpu(5);
        flush();
        wait_cpu(110);
        cpu_stop_n = 1'b0;
        wait_cpu(10);
        cpu_stop_n = 1'b1;
        arm("R5", 0, 0, 100, 102);
        wait_cpu(20);
        cpu_stop_n = 1'b0;
        wait_cpu(130);
        flush();
        check(cpu_out[0] == 1'b0, "R5", "cpu_out[0] after min run", cpu_out[0], 0);

        // R6 / R7: bus group stop, free output, minimum run
        pci_stop_n = 1'b0;
        arm("R6", 1, 1, 0, 3);
        wait_pci(4);
        flush();
        for (int i = 1; i < N_PCI; i++) arm("R6", 1, i, 0, 0);
        arm("R7", 1, 0, 19, 21);
        wait_pci(20);
        flush();
        check(pci_out[5:1] == '0, "R6", "stopped pci level", pci_out[5:1], 0);
        pci_stop_n = 1'b1;
        arm("R6", 1, 1, 10, 12);
        arm("R7", 1, 0, 32, 34);
        wait_pci(3);
        pci_stop_n = 1'b0;
        wait_pci(30);
        flush();

        // R10: memory group stop and restart
        sdr_stop_n = 1'b0;
        wait_sdr(4);
        arm("R10", 2, 0, 0, 0);
        arm("R10", 2, 12, 0, 0);
        wait_sdr(30);
        flush();
        check(sdr_out == '0, "R10", "stopped sdr level", sdr_out, 0);
        sdr_stop_n = 1'b1;
        arm("R10", 2, 0, 26, 30);
        arm("R10", 2, 12, 26, 30);
        wait_sdr(30);
        flush();

        // R3: leaving mobile mode releases held stops
        sdr_stop_n = 1'b0;
        wait_cpu(10);
        arm("R3", 0, 0, 0, 0);
        wait_cpu(20);
        flush();
        mobile_mode = 1'b0;
        wait_cpu(10);
        arm("R3", 0, 0, 39, 41);
        arm("R3", 1, 1, 9, 12);
        arm("R3", 2, 0, 31, 33);
        wait_cpu(40);
        flush();

        // R11: short stop pulses
        mobile_mode = 1'b1;
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1; sdr_stop_n = 1'b1;
        wait_cpu(120);
        arm("R11", 0, 0, 39, 41);
        cpu_stop_n = 1'b0;
        #1;
        cpu_stop_n = 1'b1;
        wait_cpu(40);
        flush();
        arm("R11", 0, 0, 36, 41);
        cpu_stop_n = 1'b0;
        #8;
        cpu_stop_n = 1'b1;
        wait_cpu(40);
        flush();

        // R2: every pulse seen at the pins was full width
        check(cpu_runt == 0, "R2", "cpu short pulses", cpu_runt, 0);
        check(pci_runt == 0, "R2", "pci short pulses", pci_runt, 0);
        check(sdr_runt == 0, "R2", "sdr short pulses", sdr_runt, 0);
        check(cpu_cnt[0] > 0 && sdr_cnt[0] > 0, "R2", "outputs toggled", cpu_cnt[0], 1);

        finish_run();
    end

endmodule